// File: doc/BRIEF.md
# Pixel-Rate DTO Clock Enable Generator

This block derives a pixel-valid enable strobe from a fast reference clock at a programmable fractional rate. A phase accumulator adds a programmed increment each reference cycle and subtracts a programmed wrap value whenever the running sum reaches it. Each wrap produces a single-cycle pulse. A second counter divides those pulses by a programmed group size and gives a group strobe.

Software uses a small configuration helper to derive the divider value, wrap value and increment from the stream setup. The inputs are the reference rate, the pixel rate, the number of horizontal segments, the chroma format, and whether compression is on without the simple 4:2:2 mode. Software then writes the group divider, wrap value and increment, and sets the enable bit. A status flag confirms the enable after a short synchronization delay. The output switches from a fallback enable input to the generated pulses only once that flag is high. A source request written before then is held pending.

Top module: `pix_dto_gen`

## Requirements
- R1: When `cfg_segments` is 4, `calc_div` is 2 and the requested rate is `cfg_pix_khz/4` (integer division).
- R2: Otherwise, the divider is 4 and the requested rate is `cfg_pix_khz/2` in any of these cases: `cfg_segments` is 2; `cfg_encoding` is 2 (4:2:0); or `cfg_encoding` is 1 (4:2:2) with `cfg_compressed`=1 and `cfg_simple422`=0.
- R3: In every remaining case, `calc_div` is 8 and the requested rate is `cfg_pix_khz`.
- R4: If `cfg_ref_khz` and the requested rate are both nonzero, then `calc_rate_ok`=1, `calc_modulo` = `cfg_ref_khz`*1000 and `calc_phase` = ceil(`calc_modulo`*rate/`cfg_ref_khz`). If either is zero, then `calc_rate_ok`=0 and `calc_modulo` = `calc_phase` = 0, while `calc_div` keeps its R1-style mode choice.
- R5: Registers are written through `wr_en`/`wr_addr`/`wr_data`. Address 0 is control: bit 0 enable, bit 1 source request, bits 7:4 group divider. Address 1 is the wrap value and address 2 is the increment. After a write that sets enable, `dto_status` reads 0 for two cycles and reads 1 from the third cycle.
- R6: In the cycle after enable is cleared, `dto_status` reads 0. Clearing enable also clears the source request, and a source request written with enable=0 is discarded.
- R7: A source request written while `dto_status`=0 stays pending. `pix_en_out` switches to the DTO pulses one cycle after `dto_status` becomes 1, and never while it is 0.
- R8: While the DTO source is not active, `pix_en_out` equals `fallback_en`.
- R9: With enable set and increment ≤ wrap value, the number of DTO pulses in N cycles is floor(N·increment/wrap) within one. A write to the wrap value or the increment restarts the accumulator at zero.
- R10: `group_strobe` pulses once for every group-divider count of DTO pulses, one cycle after the pulse that completes the group.
- R11: After reset, `dto_status`=0, `group_strobe`=0, the DTO source is inactive and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 wrap, 2 increment) |
| wr_data | input | ACC_W | Register write data |
| fallback_en | input | 1 | Pixel enable used while the DTO source is inactive |
| cfg_ref_khz | input | RATE_W | Reference rate in kHz |
| cfg_pix_khz | input | RATE_W | Pixel rate in kHz |
| cfg_segments | input | 3 | Horizontal segment count (1, 2 or 4) |
| cfg_encoding | input | 2 | Chroma format: 0 4:4:4, 1 4:2:2, 2 4:2:0 |
| cfg_compressed | input | 1 | Stream is compressed |
| cfg_simple422 | input | 1 | Compressed 4:2:2 uses the simple mode |
| calc_div | output | DIV_W | Helper: group divider value |
| calc_modulo | output | ACC_W | Helper: wrap value |
| calc_phase | output | ACC_W | Helper: increment |
| calc_rate_ok | output | 1 | Helper: both rates nonzero |
| dto_status | output | 1 | Enable confirmed |
| pix_en_out | output | 1 | Selected pixel enable |
| group_strobe | output | 1 | One pulse per divider-count DTO pulses |

## Verification
The helper is driven with each segment count, with each chroma format, with compressed 4:2:2 both with and without the simple mode, and with a zero reference rate and a pixel rate that scales to zero. These cases separate the three divider modes and the zero-rate path. The accumulator runs at quarter, third, seven-tenths and unity ratios with group sizes of 2, 4 and 8, which exposes a wrong comparison, a missed subtraction or a miscounting divider. Cycle-exact sampling around the enable write and the enable clear distinguishes the synchronizer delay, the pending source request and the fallback path. A source request written without enable confirms that it is discarded.

// File: rtl/pix_dto_pkg.sv
package pix_dto_pkg;

   typedef enum logic [1:0] {
      ENC_FULL = 2'd0,
      ENC_422  = 2'd1,
      ENC_420  = 2'd2
   } pix_enc_e;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_WRAP  = 2'd1;
   localparam logic [1:0] ADDR_INCR  = 2'd2;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_SRC_BIT = 1;
   localparam int CTRL_DIV_LSB = 4;

   localparam int unsigned KHZ_SCALE = 1000;

endpackage

// File: rtl/dto_mode_calc.sv
module dto_mode_calc
   import pix_dto_pkg::*;
#(
   parameter int RATE_W = 24,
   parameter int ACC_W  = 32,
   parameter int DIV_W  = 4
) (
   input  logic [RATE_W-1:0] ref_khz,
   input  logic [RATE_W-1:0] pix_khz,
   input  logic [2:0]        segments,
   input  logic [1:0]        encoding,
   input  logic              compressed,
   input  logic              simple422,
   output logic [DIV_W-1:0]  div,
   output logic [ACC_W-1:0]  modulo,
   output logic [ACC_W-1:0]  phase,
   output logic              rate_ok
);
   localparam int NUM_W = ACC_W + RATE_W + 1;

   if (DIV_W < 4) begin : g_bad_div
      $error("dto_mode_calc: DIV_W must hold the value 8");
   end

   logic [RATE_W-1:0] req_khz;
   logic              half_mode;
   logic [NUM_W-1:0]  numer;

   always_comb begin
      half_mode = (segments == 3'd2) || (encoding == 2'(ENC_420)) ||
                  (compressed && (encoding == 2'(ENC_422)) && !simple422);
      if (segments == 3'd4) begin
         div     = DIV_W'(2);
         req_khz = pix_khz >> 2;
      end else if (half_mode) begin
         div     = DIV_W'(4);
         req_khz = pix_khz >> 1;
      end else begin
         div     = DIV_W'(8);
         req_khz = pix_khz;
      end

      rate_ok = (ref_khz != '0) && (req_khz != '0);
      modulo  = '0;
      phase   = '0;
      numer   = '0;
      if (rate_ok) begin
         modulo = ACC_W'(NUM_W'(ref_khz) * NUM_W'(KHZ_SCALE));
         numer  = NUM_W'(modulo) * NUM_W'(req_khz) + NUM_W'(ref_khz) - NUM_W'(1);
         phase  = ACC_W'(numer / NUM_W'(ref_khz));
      end
   end

endmodule

// File: rtl/dto_phase_acc.sv
module dto_phase_acc #(
   parameter int ACC_W     = 32,
   parameter int DIV_W     = 4,
   parameter bit GROUP_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [ACC_W-1:0] modulo,
   input  logic [ACC_W-1:0] phase,
   input  logic [DIV_W-1:0] div,
   output logic             pulse,
   output logic             group_strobe
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;
   logic             wrap;

   always_comb begin
      sum  = {1'b0, acc_q} + {1'b0, phase};
      wrap = (modulo != '0) && (sum >= {1'b0, modulo});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pulse <= 1'b0;
      end else if (!en || restart || (modulo == '0)) begin
         acc_q <= '0;
         pulse <= 1'b0;
      end else if (wrap) begin
         acc_q <= ACC_W'(sum - {1'b0, modulo});
         pulse <= 1'b1;
      end else begin
         acc_q <= ACC_W'(sum);
         pulse <= 1'b0;
      end
   end

   if (GROUP_OUT) begin : g_group
      logic [DIV_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q        <= '0;
            group_strobe <= 1'b0;
         end else if (!en || restart) begin
            cnt_q        <= '0;
            group_strobe <= 1'b0;
         end else begin
            group_strobe <= 1'b0;
            if (pulse) begin
               if (({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div}) begin
                  cnt_q        <= '0;
                  group_strobe <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + DIV_W'(1);
               end
            end
         end
      end

      assert_group_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         group_strobe |-> $past(pulse));
   end else begin : g_nogroup
      assign group_strobe = 1'b0;
   end

   assert_acc_below_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && modulo != '0 && phase <= modulo) |-> (acc_q < modulo));

   assert_pulse_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(en));

endmodule

// File: rtl/dto_enable_sync.sv
module dto_enable_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic src_req,
   output logic status,
   output logic src_act
);
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dto_enable_sync: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= en;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= en & sync_q[i-1];
         end
      end
   end

   assign status = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_act <= 1'b0;
      else        src_act <= en & src_req & status;
   end

   assert_status_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(en));

   assert_status_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !status);

   assert_src_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      src_act |-> status);

endmodule

// File: rtl/pix_dto_gen.sv
module pix_dto_gen
   import pix_dto_pkg::*;
#(
   parameter int RATE_W      = 24,
   parameter int ACC_W       = 32,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit GROUP_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   input  logic              fallback_en,
   input  logic [RATE_W-1:0] cfg_ref_khz,
   input  logic [RATE_W-1:0] cfg_pix_khz,
   input  logic [2:0]        cfg_segments,
   input  logic [1:0]        cfg_encoding,
   input  logic              cfg_compressed,
   input  logic              cfg_simple422,
   output logic [DIV_W-1:0]  calc_div,
   output logic [ACC_W-1:0]  calc_modulo,
   output logic [ACC_W-1:0]  calc_phase,
   output logic              calc_rate_ok,
   output logic              dto_status,
   output logic              pix_en_out,
   output logic              group_strobe
);
   localparam int CTRL_TOP = CTRL_DIV_LSB + DIV_W;

   if (ACC_W < CTRL_TOP) begin : g_bad_width
      $error("pix_dto_gen: ACC_W too narrow for the control fields");
   end

   logic             ctrl_en_q;
   logic             ctrl_src_q;
   logic [DIV_W-1:0] ctrl_div_q;
   logic [ACC_W-1:0] wrap_q;
   logic [ACC_W-1:0] incr_q;
   logic             restart;
   logic             dto_pulse;
   logic             src_act;

   assign restart = wr_en && ((wr_addr == ADDR_WRAP) || (wr_addr == ADDR_INCR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q  <= 1'b0;
         ctrl_src_q <= 1'b0;
         ctrl_div_q <= '0;
         wrap_q     <= '0;
         incr_q     <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: begin
               ctrl_en_q  <= wr_data[CTRL_EN_BIT];
               ctrl_src_q <= wr_data[CTRL_SRC_BIT] & wr_data[CTRL_EN_BIT];
               ctrl_div_q <= wr_data[CTRL_DIV_LSB +: DIV_W];
            end
            ADDR_WRAP: wrap_q <= wr_data;
            ADDR_INCR: incr_q <= wr_data;
            default: ;
         endcase
      end
   end

   dto_mode_calc #(
      .RATE_W(RATE_W), .ACC_W(ACC_W), .DIV_W(DIV_W)
   ) i_mode (
      .ref_khz(cfg_ref_khz), .pix_khz(cfg_pix_khz), .segments(cfg_segments),
      .encoding(cfg_encoding), .compressed(cfg_compressed), .simple422(cfg_simple422),
      .div(calc_div), .modulo(calc_modulo), .phase(calc_phase), .rate_ok(calc_rate_ok)
   );

   dto_phase_acc #(
      .ACC_W(ACC_W), .DIV_W(DIV_W), .GROUP_OUT(GROUP_OUT)
   ) i_acc (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en_q), .restart(restart),
      .modulo(wrap_q), .phase(incr_q), .div(ctrl_div_q),
      .pulse(dto_pulse), .group_strobe(group_strobe)
   );

   dto_enable_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sync (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en_q), .src_req(ctrl_src_q),
      .status(dto_status), .src_act(src_act)
   );

   assign pix_en_out = src_act ? dto_pulse : fallback_en;

   assert_zero_rate_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !calc_rate_ok |-> (calc_modulo == '0 && calc_phase == '0));

   assert_div_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(calc_div) && !calc_div[0] && (calc_div <= DIV_W'(8)));

   assert_fallback_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dto_status |-> (pix_en_out == fallback_en));

endmodule

// File: tb/test_pix_dto_gen.sv
module test_pix_dto_gen;
   import pix_dto_pkg::*;

   localparam int RATE_W = 24;
   localparam int ACC_W  = 32;
   localparam int DIV_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = '0;
   logic [ACC_W-1:0]  wr_data = '0;
   logic              fallback_en = 1'b0;
   logic [RATE_W-1:0] cfg_ref_khz = '0;
   logic [RATE_W-1:0] cfg_pix_khz = '0;
   logic [2:0]        cfg_segments = 3'd1;
   logic [1:0]        cfg_encoding = '0;
   logic              cfg_compressed = 1'b0;
   logic              cfg_simple422 = 1'b0;
   logic [DIV_W-1:0]  calc_div;
   logic [ACC_W-1:0]  calc_modulo;
   logic [ACC_W-1:0]  calc_phase;
   logic              calc_rate_ok;
   logic              dto_status;
   logic              pix_en_out;
   logic              group_strobe;

   always #2 clk = ~clk;

   pix_dto_gen i_pix_dto_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fallback_en(fallback_en), .cfg_ref_khz(cfg_ref_khz), .cfg_pix_khz(cfg_pix_khz),
      .cfg_segments(cfg_segments), .cfg_encoding(cfg_encoding),
      .cfg_compressed(cfg_compressed), .cfg_simple422(cfg_simple422),
      .calc_div(calc_div), .calc_modulo(calc_modulo), .calc_phase(calc_phase),
      .calc_rate_ok(calc_rate_ok), .dto_status(dto_status), .pix_en_out(pix_en_out),
      .group_strobe(group_strobe)
   );

   typedef struct {
      string  tag;
      longint val;
      longint tol;
   } exp_item_t;

   exp_item_t exp_q[$];
   longint    obs_q[$];
   int        checks = 0;
   int        failures = 0;
   bit        done = 1'b0;

   // driver side: expected value and observation are queued together
   task automatic expect_val(input string tag, input longint e, input longint tol,
                             input longint a);
      exp_item_t it;
      it.tag = tag; it.val = e; it.tol = tol;
      exp_q.push_back(it);
      obs_q.push_back(a);
   endtask

   // monitor: pops and compares
   always @(negedge clk) begin
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
         exp_item_t it;
         longint    a;
         longint    d;
         it = exp_q.pop_front();
         a  = obs_q.pop_front();
         d  = a - it.val;
         if (d < 0) d = -d;
         checks++;
         if (d > it.tol) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", it.tag, a, it.val);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = ACC_W'(d);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   function automatic longint exp_div(input int seg, input int enc, input bit comp,
                                      input bit simp);
      if (seg == 4) return 2;
      if (seg == 2 || enc == 2 || (comp && enc == 1 && !simp)) return 4;
      return 8;
   endfunction

   task automatic check_mode(input string tag, input int refk, input int pix, input int seg,
                             input int enc, input bit comp, input bit simp);
      longint dv;
      longint rq;
      longint md;
      longint ph;
      cfg_ref_khz = RATE_W'(refk); cfg_pix_khz = RATE_W'(pix);
      cfg_segments = 3'(seg); cfg_encoding = 2'(enc);
      cfg_compressed = comp; cfg_simple422 = simp;
      #1;
      dv = exp_div(seg, enc, comp, simp);
      rq = (dv == 2) ? pix / 4 : (dv == 4) ? pix / 2 : pix;
      if (refk != 0 && rq != 0) begin
         md = longint'(refk) * 1000;
         ph = (md * rq + refk - 1) / refk;
      end else begin
         md = 0; ph = 0;
      end
      expect_val({tag, " div"}, dv, 0, longint'(calc_div));
      expect_val({"R4 modulo ", tag}, md, 0, longint'(calc_modulo));
      expect_val({"R4 phase ", tag}, ph, 0, longint'(calc_phase));
      expect_val({"R4 rate_ok ", tag}, (md != 0) ? 1 : 0, 0, longint'(calc_rate_ok));
   endtask

   task automatic run_ratio(input int ph, input int md, input int dv, input int n);
      int p;
      int g;
      longint ep;
      wr(ADDR_CTRL, 0);
      wr(ADDR_WRAP, md);
      wr(ADDR_INCR, ph);
      wr(ADDR_CTRL, (dv << 4) | 3);
      repeat (6) @(negedge clk);
      p = 0; g = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         p = p + int'(pix_en_out);
         g = g + int'(group_strobe);
      end
      ep = (longint'(n) * ph) / md;
      expect_val("R9 pulse count", ep, 1, longint'(p));
      expect_val("R10 group count", ep / dv, 1, longint'(g));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      fallback_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      expect_val("R11 status", 0, 0, longint'(dto_status));
      expect_val("R11 group", 0, 0, longint'(group_strobe));
      expect_val("R11 out=fallback", 1, 0, longint'(pix_en_out));

      // helper modes R1 R2 R3 R4
      check_mode("R1 seg4", 100, 400, 4, 0, 0, 0);
      check_mode("R2 seg2", 100, 400, 2, 0, 0, 0);
      check_mode("R2 420", 100, 400, 1, 2, 0, 0);
      check_mode("R2 c422", 100, 400, 1, 1, 1, 0);
      check_mode("R3 c422simple", 270, 333, 1, 1, 1, 1);
      check_mode("R3 plain422", 270, 333, 1, 1, 0, 0);
      check_mode("R3 full", 270, 333, 1, 0, 0, 0);
      check_mode("R4 refzero", 0, 400, 1, 0, 0, 0);
      check_mode("R4 reqzero", 100, 3, 4, 0, 0, 0);

      // R8 fallback follows input while inactive
      fallback_en = 1'b0;
      @(negedge clk);
      expect_val("R8 fallback low", 0, 0, longint'(pix_en_out));

      // R5 / R7 enable handshake with unity ratio
      wr(ADDR_WRAP, 10);
      wr(ADDR_INCR, 10);
      wr(ADDR_CTRL, (4 << 4) | 3);
      @(negedge clk);
      expect_val("R5 status c1", 0, 0, longint'(dto_status));
      expect_val("R7 pending c1", 0, 0, longint'(pix_en_out));
      @(negedge clk);
      expect_val("R5 status c2", 0, 0, longint'(dto_status));
      expect_val("R7 pending c2", 0, 0, longint'(pix_en_out));
      @(negedge clk);
      expect_val("R5 status c3", 1, 0, longint'(dto_status));
      expect_val("R7 pending c3", 0, 0, longint'(pix_en_out));
      @(negedge clk);
      expect_val("R7 switched", 1, 0, longint'(pix_en_out));

      // R6 clear enable
      fallback_en = 1'b1;
      wr(ADDR_CTRL, 0);
      @(negedge clk);
      @(negedge clk);
      expect_val("R6 status low", 0, 0, longint'(dto_status));
      expect_val("R8 fallback high", 1, 0, longint'(pix_en_out));
      fallback_en = 1'b0;
      @(negedge clk);
      expect_val("R8 fallback follows", 0, 0, longint'(pix_en_out));

      // R6 source request without enable is discarded
      wr(ADDR_CTRL, 2);
      wr(ADDR_CTRL, 1);
      repeat (5) @(negedge clk);
      expect_val("R6 status re-enabled", 1, 0, longint'(dto_status));
      expect_val("R6 src discarded", 0, 0, longint'(pix_en_out));
      @(negedge clk);
      expect_val("R6 src discarded c2", 0, 0, longint'(pix_en_out));

      // R9 / R10 rate patterns
      run_ratio(1000, 4000, 2, 1200);
      run_ratio(1000, 3000, 4, 1200);
      run_ratio(7, 10, 8, 1200);
      run_ratio(5000, 5000, 4, 1200);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule